// File: doc/BRIEF.md
# Bounded-Range Fixed-Point Divider

The block divides a signed two's complement dividend by a signed two's complement divisor and returns a signed fixed-point quotient with four integer bits and eight fractional bits. The caller guarantees, or wants to be told when it fails, that the quotient lies within plus or minus thirteen. Because of that bound, the block never computes the high-order quotient bits that must be zero. It generates only the twelve magnitude bits, one per clock, using restoring iteration on the operand magnitudes. The sign is applied at the end.

One cycle after an operation is accepted, a range gate compares the dividend magnitude against thirteen times the divisor magnitude and also tests for a zero divisor. An operation that fails either test finishes at once with an error indication and does no iteration. All other operations finish a fixed number of cycles after acceptance. The interface is a start strobe, a busy level and a one-cycle done pulse. Result and error are held from one done pulse to the next.

Top module: `div_range_lim`

## Requirements
- R1: The quotient equals the true quotient dividend/divisor scaled by 256 and truncated toward zero. It is reported as a 13-bit two's complement word whose bit 12 is the sign and whose bits 11:0 are magnitude (bits 11:8 integer, bits 7:0 fraction).
- R2: Quotients of exactly +13.00 (word 3328) and -13.00 (word -3328) are valid results, and err_o stays low for them.
- R3: When the dividend magnitude exceeds thirteen times the divisor magnitude, done_o pulses with err_o high and quo_o equal to zero.
- R4: A zero divisor gives done_o with err_o high and quo_o equal to zero, whatever the dividend is.
- R5: A result whose magnitude truncates to zero is reported as the all-zero word, never with the sign bit set, for either operand sign.
- R6: The most negative dividend (-65536) and the most negative divisor (-16384) are divided correctly.
- R7: If start_i is high at the clock edge where busy_o is low, that edge accepts the operation. A valid result appears with done_o 13 clock edges after the accepting edge. An error result appears 1 edge after it.
- R8: done_o is high for exactly one cycle per operation, and busy_o is low in that cycle, so the next operation can be started in that cycle.
- R9: start_i and the operand inputs are ignored while busy_o is high. Such a strobe does not change the running result and does not start a further operation.
- R10: After a synchronous active-high reset, busy_o, done_o and err_o are low and quo_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a division, taken while idle |
| dividend_i | input | 17 | Signed dividend, two's complement |
| divisor_i | input | 15 | Signed divisor, two's complement |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse: result and error are valid |
| err_o | output | 1 | Last operation was out of range or divided by zero |
| quo_o | output | 13 | Signed quotient, 4 integer and 8 fractional bits |

## Verification
On every cycle the assertions check the following. The done pulse lasts one cycle and never coincides with busy. Valid results arrive after exactly the run latency and error results after one cycle. An error result always carries a zero quotient. Every valid quotient lies inside plus or minus 3328. The quotient word changes only together with done. The value of each quotient, including truncation toward zero, sign handling and the most negative operands, can only be shown by the bench's scenarios, which compare against an independent integer model. The same applies to the exact boundary between +13.00 and overflow, and to a start strobe being ignored in mid-operation.

// File: rtl/drl_pkg.sv
package drl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2
  } drl_state_e;
endpackage

// File: rtl/drl_mag.sv
// Two's complement to sign and magnitude. The magnitude keeps the full
// width, so the most negative input maps to 2**(W-1) without overflow.
module drl_mag #(
  parameter int W = 17
) (
  input  logic [W-1:0] val,
  output logic         neg,
  output logic [W-1:0] mag
);
  always_comb begin
    neg = val[W-1];
    mag = neg ? (~val + 1'b1) : val;
  end
endmodule

// File: rtl/drl_gate.sv
// Range gate: flags a zero divisor and a dividend above LIMIT * divisor.
module drl_gate #(
  parameter int NW    = 17,
  parameter int DW    = 15,
  parameter int LIMIT = 13
) (
  input  logic [NW-1:0] nmag,
  input  logic [DW-1:0] dmag,
  output logic          zero_div,
  output logic          too_big
);
  localparam int PW = DW + $clog2(LIMIT + 1);
  localparam int CW = ((NW > PW) ? NW : PW) + 1;

  logic [PW-1:0] dwide;
  logic [PW-1:0] lim_prod;

  assign dwide = PW'(dmag);

  generate
    if (LIMIT == 13) begin : g_shift_add
      // 13 = 8 + 4 + 1
      assign lim_prod = (dwide << 3) + (dwide << 2) + dwide;
    end else begin : g_mult
      assign lim_prod = dwide * PW'(LIMIT);
    end
  endgenerate

  assign zero_div = (dmag == '0);
  assign too_big  = CW'(nmag) > CW'(lim_prod);
endmodule

// File: rtl/drl_step.sv
// One restoring step: shift in a dividend bit, subtract if it fits.
module drl_step #(
  parameter int DW = 15
) (
  input  logic [DW-1:0] rem_in,
  input  logic          bit_in,
  input  logic [DW-1:0] dmag,
  output logic [DW-1:0] rem_out,
  output logic          q_bit
);
  logic [DW:0] trial;
  logic [DW:0] diff;

  always_comb begin
    trial   = {rem_in, bit_in};
    diff    = trial - {1'b0, dmag};
    q_bit   = (trial >= {1'b0, dmag});
    rem_out = q_bit ? diff[DW-1:0] : trial[DW-1:0];
  end
endmodule

// File: rtl/div_range_lim.sv
module div_range_lim #(
  parameter int NW     = 17,
  parameter int DW     = 15,
  parameter int INT_W  = 4,
  parameter int FRAC_W = 8,
  parameter int LIMIT  = 13
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [NW-1:0]             dividend_i,
  input  logic [DW-1:0]             divisor_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      err_o,
  output logic [INT_W+FRAC_W:0]     quo_o
);
  import drl_pkg::*;

  localparam int QW = INT_W + FRAC_W;
  localparam int CW = $clog2(QW);

  drl_state_e    st;
  logic [NW-1:0] n_mag_r;
  logic [DW-1:0] d_mag_r;
  logic          neg_r;
  logic [DW-1:0] rem_r;
  logic [QW-1:0] feed_r;
  logic [QW-1:0] q_r;
  logic [CW-1:0] cnt_r;

  logic          n_neg, d_neg;
  logic [NW-1:0] n_mag;
  logic [DW-1:0] d_mag;
  logic          zero_div, too_big;
  logic [DW-1:0] rem_nx;
  logic          q_bit;
  logic [QW-1:0] q_nx;
  logic [QW:0]   q_ext;

  drl_mag #(.W(NW)) u_nmag (.val(dividend_i), .neg(n_neg), .mag(n_mag));
  drl_mag #(.W(DW)) u_dmag (.val(divisor_i),  .neg(d_neg), .mag(d_mag));

  drl_gate #(.NW(NW), .DW(DW), .LIMIT(LIMIT)) u_gate (
    .nmag     (n_mag_r),
    .dmag     (d_mag_r),
    .zero_div (zero_div),
    .too_big  (too_big)
  );

  drl_step #(.DW(DW)) u_step (
    .rem_in  (rem_r),
    .bit_in  (feed_r[QW-1]),
    .dmag    (d_mag_r),
    .rem_out (rem_nx),
    .q_bit   (q_bit)
  );

  assign q_nx   = {q_r[QW-2:0], q_bit};
  assign q_ext  = {1'b0, q_nx};
  assign busy_o = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      n_mag_r <= '0;
      d_mag_r <= '0;
      neg_r   <= 1'b0;
      rem_r   <= '0;
      feed_r  <= '0;
      q_r     <= '0;
      cnt_r   <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      quo_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_i) begin
            n_mag_r <= n_mag;
            d_mag_r <= d_mag;
            neg_r   <= n_neg ^ d_neg;
            st      <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (zero_div || too_big) begin
            err_o  <= 1'b1;
            quo_o  <= '0;
            done_o <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            // Quotient below 2**QW means the top bits of the dividend
            // already form a remainder smaller than the divisor.
            rem_r  <= DW'(n_mag_r >> INT_W);
            feed_r <= {n_mag_r[INT_W-1:0], {FRAC_W{1'b0}}};
            q_r    <= '0;
            cnt_r  <= CW'(QW - 1);
            st     <= ST_RUN;
          end
        end
        ST_RUN: begin
          rem_r  <= rem_nx;
          feed_r <= feed_r << 1;
          q_r    <= q_nx;
          if (cnt_r == '0) begin
            err_o  <= 1'b0;
            quo_o  <= (neg_r && (q_nx != '0)) ? (~q_ext + 1'b1) : q_ext;
            done_o <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            cnt_r <= cnt_r - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/div_range_lim_chk.sv
module div_range_lim_chk #(
  parameter int INT_W  = 4,
  parameter int FRAC_W = 8,
  parameter int LIMIT  = 13
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  busy_o,
  input logic                  done_o,
  input logic                  err_o,
  input logic [INT_W+FRAC_W:0] quo_o
);
  localparam int QW  = INT_W + FRAC_W;
  localparam int LQ  = LIMIT << FRAC_W;
  localparam int YW  = $clog2(QW + 4) + 1;

  logic [YW-1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else     cyc <= busy_o ? cyc + 1'b1 : '0;
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  a_r7_run_latency: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o) |-> (cyc == YW'(QW + 1)));

  a_r7_err_latency: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (cyc == YW'(1)));

  a_r3_err_zero_quo: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (quo_o == '0));

  a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o) |-> (($signed(quo_o) <= LQ) && ($signed(quo_o) >= -LQ)));

  a_r1_quo_held: assert property (@(posedge clk) disable iff (rst)
    !$stable(quo_o) |-> done_o);
endmodule

bind div_range_lim div_range_lim_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .LIMIT(LIMIT)
) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .quo_o(quo_o)
);

// File: tb/sim_div_range_lim.sv
module sim_div_range_lim;
  localparam int CLK_NS = 10;
  localparam int ERRV   = 32'h7fffffff;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [16:0] dividend_i = '0;
  logic [14:0] divisor_i = '0;
  logic        busy_o, done_o, err_o;
  logic [12:0] quo_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  div_range_lim u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .dividend_i(dividend_i),
    .divisor_i(divisor_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .quo_o(quo_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic int exp_q(input int n, input int d);
    int an, ad, q;
    an = (n < 0) ? -n : n;
    ad = (d < 0) ? -d : d;
    if (ad == 0 || an > 13 * ad) return ERRV;
    q = (an * 256) / ad;
    return (((n < 0) != (d < 0)) ? -q : q);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Run one division; optionally strobe start with other operands mid-run (R9).
  task automatic do_op(input int n, input int d, input bit poke, input string req);
    int k;
    bit got;
    int e;
    e = exp_q(n, d);
    @(negedge clk);
    dividend_i = n[16:0];
    divisor_i  = d[14:0];
    start_i    = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    got = 0;
    while (!got && k < 40) begin
      @(negedge clk);
      k++;
      if (done_o) got = 1;
      else if (poke && k == 3) begin
        dividend_i = 17'h00101;
        divisor_i  = 15'h0003;
        start_i    = 1'b1;
      end else start_i = 1'b0;
    end
    start_i = 1'b0;
    if (e == ERRV) begin
      chk(err_o == 1'b1, {req, " err flag"}, int'(err_o), 1);
      chk(quo_o == '0, {req, " quo on error"}, int'($signed(quo_o)), 0);
      chk(k == 1, "R7 error latency", k, 1);
    end else begin
      chk(err_o == 1'b0, {req, " err flag"}, int'(err_o), 0);
      chk(int'($signed(quo_o)) == e, {req, " quotient"}, int'($signed(quo_o)), e);
      chk(k == 13, "R7 run latency", k, 13);
    end
    chk(got, "R8 done seen", int'(got), 1);
    @(negedge clk);
    chk(!done_o, "R8 done one cycle", int'(done_o), 0);
    if (poke) begin
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (done_o || busy_o) begin
          chk(1'b0, "R9 extra operation", int'(busy_o), 0);
          break;
        end
      end
      chk(!busy_o, "R9 idle after ignored start", int'(busy_o), 0);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int d, n, r, mode;
    void'($urandom(1234));
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(!busy_o, "R10 busy", int'(busy_o), 0);
    chk(!done_o, "R10 done", int'(done_o), 0);
    chk(!err_o,  "R10 err",  int'(err_o), 0);
    chk(quo_o == '0, "R10 quo", int'(quo_o), 0);
    rst = 1'b0;

    do_op(13000, 1000, 0, "R2 +13");
    do_op(-13000, 1000, 0, "R2 -13");
    do_op(13001, 1000, 0, "R3 just over");
    do_op(-65535, 3, 0, "R3 large");
    do_op(12345, 0, 0, "R4 zero divisor");
    do_op(0, 0, 0, "R4 zero by zero");
    do_op(0, -5, 0, "R5 zero dividend");
    do_op(-1, 16383, 0, "R5 tiny negative");
    do_op(-65536, -16384, 0, "R6 both most negative");
    do_op(-65536, 5041, 0, "R6 over limit");
    do_op(-65536, 5042, 0, "R6 near limit");
    do_op(65535, -16384, 0, "R1 truncation");
    do_op(7, 3, 0, "R1 small");
    do_op(5000, 2000, 1, "R9 start while busy");

    for (int i = 0; i < 400; i++) begin
      d = int'($urandom_range(32767, 0)) - 16384;
      mode = int'($urandom % 3);
      if (mode == 0) n = int'($urandom_range(131071, 0)) - 65536;
      else begin
        r = int'($urandom_range(13 * 256 + 40, 0));
        n = (d * r) / 256;
        if ($urandom % 2) n = -n;
        if (n > 65535) n = 65535;
        if (n < -65536) n = -65536;
      end
      do_op(n, d, 0, "R1 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule